// File: doc/BRIEF.md
# Radio Power Sequencing Controller

This block decides when a mobile radio's main supply rail is switched on and when the processor is allowed out of reset. Power is requested by a wired-OR of three sources: the front-panel switched-battery level, a soft-hold line that the processor drives, and an emergency one-shot started by a footswitch. The soft-hold input lets the processor keep itself powered after the switch is turned off. It uses that time to finish a graceful shutdown, then lets the rail drop.

The switched-battery and unswitched-supply comparator levels, and the footswitch, are synchronized with two flip-flops and then debounced. A change passes only after it has been stable for `DEB_CYC` clocks. The two supply levels are combined into a sense status for the processor. An active footswitch edge loads a hold timer of `(CLK_HZ/1000)*HOLD_MS` clocks (300 ms by default). The timer keeps power on whatever the switch does, and it raises an emergency-sense status that the processor polls before it raises soft-hold. A strap input selects which footswitch level counts as active.

The active-low power-on reset is asserted when power is off, or in the same cycle as any regulator error flag or the low-supply detector flag. It is released only after power has been on and every supply has been good for `POR_STRETCH` clocks in a row.

A four-state machine holds the power decision:
- **ST_OFF**: no source is active.
- **ST_RUN**: the switch is active.
- **ST_EMERG**: the switch is off and the emergency timer is running.
- **ST_HOLD**: only soft-hold keeps power on.

Every state uses the same priority to pick its next state: switch first, then timer, then soft-hold, else ST_OFF. The named transitions are:
- T_SWITCH_ON: any state to ST_RUN.
- T_EMERG_TAKEOVER: any state to ST_EMERG.
- T_SOFT_KEEP: any state to ST_HOLD.
- T_RELEASE: any state to ST_OFF.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `pwr_en` is high when the debounced switch level is high, or `soft_hold` is high, or the emergency timer is running. It follows the source one clock after the source's debounced or registered value changes.
- R2: `swb_sense` is high exactly when both the debounced `swb_lvl` and the debounced `supa_lvl` are high (1 = above threshold).
- R3: After the switch goes low while `soft_hold` is high, `pwr_en` stays high and `swb_sense` is low. `pwr_en` falls only once the switch and `soft_hold` are both low and the timer is idle.
- R4: An active footswitch edge holds `pwr_en` high for `(CLK_HZ/1000)*HOLD_MS` clocks regardless of the switch, and `emerg_sense` is high for exactly that interval.
- R5: With `emerg_pol` = 0, the footswitch is active when `foot_open` = 1. With `emerg_pol` = 1, it is active when `foot_open` = 0. A strap change that leaves the active level low does not start the timer.
- R6: A new active edge while the timer is running reloads it to the full interval.
- R7: `por_n` is low in the same cycle as any bit of `reg_err` or `lowv_trip` being high.
- R8: `por_n` rises only after `pwr_en` is high and all faults are clear for `POR_STRETCH` consecutive clocks. Any fault restarts that count.
- R9: `por_n` is low whenever `pwr_en` is low.
- R10: A change on `swb_lvl`, `supa_lvl` or `foot_open` lasting fewer than `DEB_CYC` clocks has no effect on any output.
- R11: While and right after reset, `pwr_en`, `por_n`, `swb_sense` and `emerg_sense` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| swb_lvl | input | 1 | Switched-battery comparator, 1 = above threshold |
| supa_lvl | input | 1 | Unswitched-supply comparator, 1 = above threshold |
| soft_hold | input | 1 | Processor hold-on line, synchronous |
| foot_open | input | 1 | Footswitch, 1 = open, 0 = grounded |
| emerg_pol | input | 1 | Polarity strap, 0 = active open, 1 = active closed |
| reg_err | input | NUM_REG | Regulator error flags, 1 = failed |
| lowv_trip | input | 1 | Low-supply detector flag, 1 = tripped |
| pwr_en | output | 1 | Main power enable |
| por_n | output | 1 | Active-low processor reset |
| swb_sense | output | 1 | Switched-battery sense status |
| emerg_sense | output | 1 | Emergency activation status |

## Verification
A table walks all eight combinations of switch level, supply level and soft-hold with no emergency active. This separates the OR that drives `pwr_en` from the AND that drives `swb_sense`, and it shows that reset follows power.

Directed footswitch sequences check four things:
- The hold length, by sampling just before and just after the expected expiry.
- Retriggering, by sampling at a point that only a reloaded timer reaches.
- Both strap polarities.
- That a strap change alone starts nothing.

Short glitches on the debounced inputs show that they are rejected. Fault injection with the rail on shows that reset asserts in the same cycle, and that the stretch count restarts after the fault clears.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_EMERG = 2'd2,
        ST_HOLD  = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/pwr_sync_deb.sv
module pwr_sync_deb #(
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            cnt  <= '0;
            dout <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 == dout) begin
                cnt <= '0;
            end else if (cnt == CW'(DEB_CYC - 1)) begin
                cnt  <= '0;
                dout <= s2;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10: the filtered level only moves after a full stable window
    p_deb_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(s2) != $past(dout)));
endmodule

// File: rtl/pwr_emerg_timer.sv
module pwr_emerg_timer #(
    parameter int HOLD_CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic running
);
    localparam int TW = $clog2(HOLD_CYC + 1);

    logic          act_q;
    logic          trig;
    logic [TW-1:0] remain;

    assign trig    = act & ~act_q;
    assign running = (remain != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            remain <= '0;
        end else begin
            act_q <= act;
            if (trig)
                remain <= TW'(HOLD_CYC);
            else if (remain != '0)
                remain <= remain - 1'b1;
        end
    end

    // R4/R6: an active edge always leaves the timer running
    p_trig_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> running);
    // R6: a retrigger reloads the full interval
    p_reload_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (remain == TW'(HOLD_CYC)));
endmodule

// File: rtl/pwr_por_gen.sv
module pwr_por_gen #(
    parameter int POR_STRETCH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic fault,
    output logic por_n
);
    localparam int SW = $clog2(POR_STRETCH + 1);

    logic [SW-1:0] good_cnt;
    logic          good_done;

    assign good_done = (good_cnt == SW'(POR_STRETCH));
    assign por_n     = pwr_en & ~fault & good_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            good_cnt <= '0;
        else if (!pwr_en || fault)
            good_cnt <= '0;
        else if (!good_done)
            good_cnt <= good_cnt + 1'b1;
    end

    // R8: reset cannot release in the cycle right after a fault or power-off
    p_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault || !pwr_en) |=> !por_n);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int CLK_HZ      = 16_800_000,
    parameter int HOLD_MS     = 300,
    parameter int DEB_CYC     = 4,
    parameter int POR_STRETCH = 8,
    parameter int NUM_REG     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swb_lvl,
    input  logic               supa_lvl,
    input  logic               soft_hold,
    input  logic               foot_open,
    input  logic               emerg_pol,
    input  logic [NUM_REG-1:0] reg_err,
    input  logic               lowv_trip,
    output logic               pwr_en,
    output logic               por_n,
    output logic               swb_sense,
    output logic               emerg_sense
);
    localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;
    localparam int NUM_IN   = 3;

    logic [NUM_IN-1:0] raw_in, deb_in;
    logic              swb_d, supa_d, foot_d;
    logic              emerg_act, tmr_run, fault;
    pwr_state_t        state, nxt;

    assign raw_in = {foot_open, supa_lvl, swb_lvl};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_deb
        pwr_sync_deb #(.DEB_CYC(DEB_CYC)) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[i]),
            .dout (deb_in[i])
        );
    end

    assign swb_d  = deb_in[0];
    assign supa_d = deb_in[1];
    assign foot_d = deb_in[2];

    assign emerg_act = emerg_pol ? ~foot_d : foot_d;

    pwr_emerg_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (emerg_act),
        .running(tmr_run)
    );

    function automatic pwr_state_t pick(input logic sw, input logic tm, input logic sh);
        if (sw)      return ST_RUN;
        else if (tm) return ST_EMERG;
        else if (sh) return ST_HOLD;
        else         return ST_OFF;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   nxt = pick(swb_d, tmr_run, soft_hold);
            ST_RUN:   if (!swb_d) nxt = pick(1'b0, tmr_run, soft_hold);
            ST_EMERG: if (swb_d || !tmr_run) nxt = pick(swb_d, tmr_run, soft_hold);
            ST_HOLD:  nxt = pick(swb_d, tmr_run, soft_hold);
            default:  nxt = ST_OFF;
        endcase
    end

    always_comb begin
        pwr_en = 1'b0;
        unique case (state)
            ST_OFF:   pwr_en = 1'b0;
            ST_RUN,
            ST_EMERG,
            ST_HOLD:  pwr_en = 1'b1;
            default:  pwr_en = 1'b0;
        endcase
    end

    assign swb_sense   = swb_d & supa_d;
    assign emerg_sense = tmr_run;
    assign fault       = (|reg_err) | lowv_trip;

    pwr_por_gen #(.POR_STRETCH(POR_STRETCH)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .pwr_en(pwr_en),
        .fault (fault),
        .por_n (por_n)
    );

    // R1: any active source turns power on next cycle
    p_req_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (swb_d || soft_hold || tmr_run) |=> pwr_en);
    // R3: power drops only when every source is idle
    p_all_low_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!swb_d && !soft_hold && !tmr_run) |=> !pwr_en);
    // R7: any fault holds reset low
    p_fault_por_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !por_n);
    // R9: no reset release without power
    p_off_por_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> !por_n);
    // R4: the emergency status implies power
    p_emerg_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        emerg_sense |=> pwr_en);
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 3;
    localparam int HOLD = 3000; // (10000/1000)*300

    logic clk = 1'b0, rst_n = 1'b0;
    logic swb_lvl = 0, supa_lvl = 0, soft_hold = 0, foot_open = 0, emerg_pol = 0, lowv_trip = 0;
    logic [NREG-1:0] reg_err = '0;
    logic pwr_en, por_n, swb_sense, emerg_sense;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_ctrl #(.CLK_HZ(10_000), .HOLD_MS(300), .DEB_CYC(4),
                   .POR_STRETCH(8), .NUM_REG(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .swb_lvl(swb_lvl), .supa_lvl(supa_lvl),
        .soft_hold(soft_hold), .foot_open(foot_open), .emerg_pol(emerg_pol),
        .reg_err(reg_err), .lowv_trip(lowv_trip), .pwr_en(pwr_en), .por_n(por_n),
        .swb_sense(swb_sense), .emerg_sense(emerg_sense));

    // inputs {swb,supa,soft} -> expected {pwr_en,swb_sense,por_n}
    localparam logic [5:0] VEC [0:7] = '{6'b000_000, 6'b001_101, 6'b010_000, 6'b011_101,
                                         6'b100_101, 6'b101_101, 6'b110_111, 6'b111_111};

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen;
        cyc(3);
        // R11 reset state
        chk("R11 pwr_en", pwr_en, 1'b0);
        chk("R11 por_n", por_n, 1'b0);
        chk("R11 swb_sense", swb_sense, 1'b0);
        chk("R11 emerg_sense", emerg_sense, 1'b0);
        rst_n = 1'b1;
        cyc(2);
        chk("R11 pwr_en after release", pwr_en, 1'b0);

        // R1 R2 R9 table walk
        for (int i = 0; i < 8; i++) begin
            {swb_lvl, supa_lvl, soft_hold} = VEC[i][5:3];
            cyc(20);
            chk("R1 pwr_en table", pwr_en, VEC[i][2]);
            chk("R2 swb_sense table", swb_sense, VEC[i][1]);
            chk("R9 por_n table", por_n, VEC[i][0]);
        end

        // R3 soft shutdown
        swb_lvl = 1; supa_lvl = 1; soft_hold = 0; cyc(20);
        soft_hold = 1; swb_lvl = 0; cyc(20);
        chk("R3 held on", pwr_en, 1'b1);
        chk("R3 sense low", swb_sense, 1'b0);
        soft_hold = 0; cyc(3);
        chk("R3 off after release", pwr_en, 1'b0);
        chk("R9 por after off", por_n, 1'b0);

        // R10 glitch rejection
        seen = 0;
        swb_lvl = 1; cyc(3); swb_lvl = 0;
        for (int k = 0; k < 20; k++) begin cyc(1); if (pwr_en) seen = 1; end
        chk("R10 switch glitch ignored", seen, 1'b0);
        swb_lvl = 1; supa_lvl = 1; cyc(20);
        seen = 0;
        supa_lvl = 0; cyc(3); supa_lvl = 1;
        for (int k = 0; k < 20; k++) begin cyc(1); if (!swb_sense) seen = 1; end
        chk("R10 supply glitch ignored", seen, 1'b0);

        // R7 R8 faults
        chk("R8 por released", por_n, 1'b1);
        reg_err = 3'b010; #1;
        chk("R7 reg_err immediate", por_n, 1'b0);
        cyc(3); reg_err = '0; cyc(4);
        chk("R8 still stretched", por_n, 1'b0);
        cyc(6);
        chk("R8 released after stretch", por_n, 1'b1);
        lowv_trip = 1; #1;
        chk("R7 lowv immediate", por_n, 1'b0);
        cyc(2); lowv_trip = 0; cyc(12);
        chk("R8 released after lowv", por_n, 1'b1);
        swb_lvl = 0; supa_lvl = 0; cyc(20);

        // R10 footswitch glitch
        seen = 0;
        foot_open = 1; cyc(3); foot_open = 0;
        for (int k = 0; k < 20; k++) begin cyc(1); if (emerg_sense) seen = 1; end
        chk("R10 foot glitch ignored", seen, 1'b0);

        // R4 emergency hold, default polarity (R5)
        foot_open = 1; cyc(100);
        chk("R4 emerg_sense on", emerg_sense, 1'b1);
        chk("R5 pol0 open powers", pwr_en, 1'b1);
        cyc(HOLD - 200);
        chk("R4 still held", pwr_en, 1'b1);
        cyc(200);
        chk("R4 expired pwr", pwr_en, 1'b0);
        chk("R4 expired sense", emerg_sense, 1'b0);

        // R6 retrigger
        foot_open = 0; cyc(20); foot_open = 1; cyc(2000);
        foot_open = 0; cyc(20); foot_open = 1;
        cyc(2800);
        chk("R6 retrigger extends", pwr_en, 1'b1);
        cyc(400);
        chk("R6 expires after reload", emerg_sense, 1'b0);

        // R5 alternate polarity
        emerg_pol = 1; cyc(50);
        chk("R5 strap change no trigger", emerg_sense, 1'b0);
        foot_open = 0; cyc(100);
        chk("R5 pol1 closed triggers", emerg_sense, 1'b1);
        chk("R5 pol1 powers", pwr_en, 1'b1);
        cyc(HOLD + 100);
        chk("R5 pol1 expired", pwr_en, 1'b0);
        foot_open = 1; cyc(50);
        chk("R5 pol1 open inactive", emerg_sense, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule